// File: doc/BRIEF.md
# Microcontroller Instruction Word Decoder

A purely combinational decoder for the 16-bit instruction words of a small 8-bit microcontroller core. One word enters on `insn_i`; in the same cycle the block produces an operation code and every operand the execute stage needs. The operands are a destination register index, a source register index (both 0 to 31), an 8-bit immediate, a 6-bit I/O address, a 3-bit bit number and a 2-bit register-pair index. Fetch, execution and the two-word instruction forms sit outside this block.

Operand fields are spread over the word in pieces that do not sit next to each other, and the block puts them back together. An add whose two register fields name the same register is reported as a left shift. Any word that matches no supported pattern raises `illegal_o`. Every operand field that the selected operation does not use is driven to zero.

Top module: `mcu_insn_decoder`

## Requirements
- R1: The words 0000 11rd dddd rrrr (add), 0001 11 (add with carry), 0001 10 (subtract), 0000 10 (subtract with carry), 0010 00 (AND), 0010 01 (XOR) and 0010 10 (OR) decode to their operations. The destination is bits 8:4, and the source is bit 9 followed by bits 3:0.
- R2: An add word whose destination and source fields are equal decodes as shift left, with both indices equal. If the fields differ, the word decodes as add.
- R3: The word 1001 11rd dddd rrrr decodes as multiply, with its operand fields placed as in R1.
- R4: The high nibbles 0111 (AND), 0110 (OR), 0101 (subtract) and 0100 (subtract with carry) select the immediate forms. The immediate is bits 11:8 followed by bits 3:0. The destination is 16 plus bits 7:4.
- R5: Words with bits 15:9 equal to 1001010 are one-operand forms, selected by bits 3:0. The codes are 0000 complement, 0010 nibble swap, 0011 increment, 0101 arithmetic shift right, 0110 logical shift right and 1010 decrement. Their destination is bits 8:4.
- R6: Bits 15:11 of 10110 select port read, and 10111 selects port write. The 6-bit address is bits 10:9 followed by bits 3:0. Bits 8:4 are the destination for a read and the source for a write.
- R7: When bits 3:0 are 1111, bits 15:9 of 1001001 select push, with the source in bits 8:4. Bits 15:9 of 1001000 select pop, with the destination in bits 8:4.
- R8: A high byte of 0x98 selects clear I/O bit, and 0x9A selects set I/O bit. The address is bits 7:3, zero-extended to 6 bits. The bit number is bits 2:0.
- R9: A high byte of 0x96 selects word add-immediate, and 0x97 selects word subtract-immediate. The pair index is bits 5:4. The destination is 24 plus twice the pair index. The immediate is bits 7:6 followed by bits 3:0, zero-extended.
- R10: Any other word raises illegal_o, gives the illegal operation code, and drives all operand outputs to zero.
- R11: Every operand output that the decoded operation does not use is zero.
- R12: The outputs depend only on the present word, with no register in the path. A change of the word is visible before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Instruction word to decode |
| op_o | output | 5 | Operation code (idec_pkg::op_e) |
| illegal_o | output | 1 | Word matches no supported pattern |
| rd_o | output | 5 | Destination register index |
| rr_o | output | 5 | Source register index |
| imm_o | output | 8 | Immediate constant |
| io_addr_o | output | 6 | I/O address |
| bit_o | output | 3 | Bit number for I/O bit operations |
| pair_o | output | 2 | Register-pair index for word operations |

## Verification
The block holds no state. A fault therefore shows in the same cycle as a wrong operation code or a wrongly assembled field, and the word that exposes it exposes it every time it is applied. Faults most likely hide in the seams between scattered field pieces, in the operand-equality alias and in the edges of prefix matching, such as a one-operand selector just beside a legal one. Because of this, all 65536 words are compared against an independent behavioural model, together with directed corner words at the field extremes.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int unsigned INSN_W       = 16;
  localparam int unsigned FIELD_SRC_W  = 12;
  localparam int unsigned REG_W        = 5;
  localparam int unsigned IMM_W        = 8;
  localparam int unsigned IO_W         = 6;
  localparam int unsigned BIT_W        = 3;
  localparam int unsigned PAIR_W       = 2;
  localparam int unsigned OP_W         = 5;
  localparam int unsigned HI_BANK_BASE = 16;
  localparam int unsigned PAIR_BASE    = 24;

  typedef enum logic [OP_W-1:0] {
    OP_ILLEGAL, OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_AND, OP_XOR, OP_OR,
    OP_MUL, OP_SHL, OP_ANDK, OP_ORK, OP_SUBK, OP_SUBCK, OP_NOT, OP_NSWAP,
    OP_INC, OP_SHRA, OP_SHRL, OP_DEC, OP_PIN, OP_POUT, OP_PUSH, OP_POP,
    OP_BCLR, OP_BSET, OP_WADDK, OP_WSUBK
  } op_e;

  typedef enum logic [3:0] {
    FMT_NONE, FMT_RR, FMT_DK, FMT_D, FMT_S, FMT_DIO, FMT_SIO, FMT_IOB, FMT_PK
  } fmt_e;

  typedef struct packed {
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src_split;
    logic [REG_W-2:0]  dst_hi;
    logic [IMM_W-1:0]  k8;
    logic [IO_W-1:0]   io6;
    logic [IO_W-2:0]   io5;
    logic [BIT_W-1:0]  bitn;
    logic [PAIR_W-1:0] pair;
    logic [IMM_W-1:0]  k6;
  } fields_t;

  function automatic fmt_e fmt_of(op_e op);
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_AND, OP_XOR, OP_OR, OP_MUL, OP_SHL:
        return FMT_RR;
      OP_ANDK, OP_ORK, OP_SUBK, OP_SUBCK:                 return FMT_DK;
      OP_NOT, OP_NSWAP, OP_INC, OP_SHRA, OP_SHRL, OP_DEC, OP_POP:
        return FMT_D;
      OP_PUSH:                                           return FMT_S;
      OP_PIN:                                            return FMT_DIO;
      OP_POUT:                                           return FMT_SIO;
      OP_BCLR, OP_BSET:                                  return FMT_IOB;
      OP_WADDK, OP_WSUBK:                                return FMT_PK;
      default:                                           return FMT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [FIELD_SRC_W-1:0] fld_word_i,
  output fields_t                fld_o
);
  always_comb begin
    fld_o.dst       = fld_word_i[8:4];
    fld_o.src_split = {fld_word_i[9], fld_word_i[3:0]};
    fld_o.dst_hi    = fld_word_i[7:4];
    fld_o.k8        = {fld_word_i[11:8], fld_word_i[3:0]};
    fld_o.io6       = {fld_word_i[10:9], fld_word_i[3:0]};
    fld_o.io5       = fld_word_i[7:3];
    fld_o.bitn      = fld_word_i[2:0];
    fld_o.pair      = fld_word_i[5:4];
    fld_o.k6        = {2'b00, fld_word_i[7:6], fld_word_i[3:0]};
  end
endmodule

// File: rtl/idec_class.sv
module idec_class
  import idec_pkg::*;
(
  input  logic [INSN_W-1:0] cls_word_i,
  input  logic              regs_equal_i,
  output op_e               cls_op_o
);
  always_comb begin
    cls_op_o = OP_ILLEGAL;
    casez (cls_word_i)
      16'b0000_11??_????_????: cls_op_o = regs_equal_i ? OP_SHL : OP_ADD;
      16'b0001_11??_????_????: cls_op_o = OP_ADDC;
      16'b0001_10??_????_????: cls_op_o = OP_SUB;
      16'b0000_10??_????_????: cls_op_o = OP_SUBC;
      16'b0010_00??_????_????: cls_op_o = OP_AND;
      16'b0010_01??_????_????: cls_op_o = OP_XOR;
      16'b0010_10??_????_????: cls_op_o = OP_OR;
      16'b1001_11??_????_????: cls_op_o = OP_MUL;
      16'b0111_????_????_????: cls_op_o = OP_ANDK;
      16'b0110_????_????_????: cls_op_o = OP_ORK;
      16'b0101_????_????_????: cls_op_o = OP_SUBK;
      16'b0100_????_????_????: cls_op_o = OP_SUBCK;
      16'b1001_010?_????_0000: cls_op_o = OP_NOT;
      16'b1001_010?_????_0010: cls_op_o = OP_NSWAP;
      16'b1001_010?_????_0011: cls_op_o = OP_INC;
      16'b1001_010?_????_0101: cls_op_o = OP_SHRA;
      16'b1001_010?_????_0110: cls_op_o = OP_SHRL;
      16'b1001_010?_????_1010: cls_op_o = OP_DEC;
      16'b1011_0???_????_????: cls_op_o = OP_PIN;
      16'b1011_1???_????_????: cls_op_o = OP_POUT;
      16'b1001_001?_????_1111: cls_op_o = OP_PUSH;
      16'b1001_000?_????_1111: cls_op_o = OP_POP;
      16'b1001_1000_????_????: cls_op_o = OP_BCLR;
      16'b1001_1010_????_????: cls_op_o = OP_BSET;
      16'b1001_0110_????_????: cls_op_o = OP_WADDK;
      16'b1001_0111_????_????: cls_op_o = OP_WSUBK;
      default:                 cls_op_o = OP_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/mcu_insn_decoder.sv
module mcu_insn_decoder
  import idec_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output logic [OP_W-1:0]   op_o,
  output logic              illegal_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rr_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [IO_W-1:0]   io_addr_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [PAIR_W-1:0] pair_o
);
  fields_t fld;
  op_e     op;
  fmt_e    fmt;

  idec_fields u_fields (
    .fld_word_i (insn_i[FIELD_SRC_W-1:0]),
    .fld_o      (fld)
  );

  // alias detection compares the reassembled fields, not raw bits
  idec_class u_class (
    .cls_word_i   (insn_i),
    .regs_equal_i (fld.dst == fld.src_split),
    .cls_op_o     (op)
  );

  assign fmt       = fmt_of(op);
  assign op_o      = op;
  assign illegal_o = (fmt == FMT_NONE);

  always_comb begin
    rd_o      = '0;
    rr_o      = '0;
    imm_o     = '0;
    io_addr_o = '0;
    bit_o     = '0;
    pair_o    = '0;
    case (fmt)
      FMT_RR:  begin rd_o = fld.dst; rr_o = fld.src_split; end
      FMT_DK:  begin
        rd_o  = REG_W'(HI_BANK_BASE) | {1'b0, fld.dst_hi};
        imm_o = fld.k8;
      end
      FMT_D:   rd_o = fld.dst;
      FMT_S:   rr_o = fld.dst;
      FMT_DIO: begin rd_o = fld.dst; io_addr_o = fld.io6; end
      FMT_SIO: begin rr_o = fld.dst; io_addr_o = fld.io6; end
      FMT_IOB: begin io_addr_o = {1'b0, fld.io5}; bit_o = fld.bitn; end
      FMT_PK:  begin
        pair_o = fld.pair;
        rd_o   = REG_W'(PAIR_BASE) | {2'b00, fld.pair, 1'b0};
        imm_o  = fld.k6;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (illegal_o)
      assert_illegal_zero_R10: assert ((rd_o | rr_o) == '0 && imm_o == '0 &&
                                       io_addr_o == '0 && bit_o == '0 && pair_o == '0);
    if (op_o == OP_SHL)
      assert_alias_equal_R2: assert (rd_o == rr_o);
    if (op_o inside {OP_ANDK, OP_ORK, OP_SUBK, OP_SUBCK})
      assert_upper_bank_R4: assert (rd_o[REG_W-1] && rr_o == '0);
    if (op_o inside {OP_WADDK, OP_WSUBK})
      assert_pair_even_R9: assert (!rd_o[0] && rd_o >= REG_W'(PAIR_BASE) &&
                                   imm_o[IMM_W-1:IMM_W-2] == 2'b00);
    if (op_o inside {OP_BCLR, OP_BSET})
      assert_bit_addr_R8: assert (!io_addr_o[IO_W-1] && rd_o == '0 && rr_o == '0);
  end
endmodule

// File: tb/mcu_insn_decoder_tb_top.sv
module mcu_insn_decoder_tb_top;
  import idec_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] word = '0;
  logic [4:0]  op_o;
  logic        illegal_o;
  logic [4:0]  rd_o, rr_o;
  logic [7:0]  imm_o;
  logic [5:0]  io_addr_o;
  logic [2:0]  bit_o;
  logic [1:0]  pair_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcu_insn_decoder dut_i (
    .insn_i(word), .op_o(op_o), .illegal_o(illegal_o), .rd_o(rd_o), .rr_o(rr_o),
    .imm_o(imm_o), .io_addr_o(io_addr_o), .bit_o(bit_o), .pair_o(pair_o)
  );

  task automatic chk(string tag, string what, int w, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s word=%04h %s act=%0h exp=%0h", tag, w, what, act, exp);
    end
  endtask

  // behavioural model; used bits: 0 rd 1 rr 2 imm 3 io 4 bit 5 pair
  task automatic model(input int w, output op_e op, output int rd, output int rr,
                       output int imm, output int io, output int bt, output int pr,
                       output int used, output string tag);
    int d, r, lo;
    d = (w >> 4) & 31; r = ((w >> 5) & 16) | (w & 15); lo = w & 15;
    op = OP_ILLEGAL; rd = 0; rr = 0; imm = 0; io = 0; bt = 0; pr = 0; used = 0; tag = "R10";
    case (w >> 10)
      3:  begin op = (d == r) ? OP_SHL : OP_ADD; tag = (d == r) ? "R2" : "R1"; end
      7:  begin op = OP_ADDC; tag = "R1"; end
      6:  begin op = OP_SUB;  tag = "R1"; end
      2:  begin op = OP_SUBC; tag = "R1"; end
      8:  begin op = OP_AND;  tag = "R1"; end
      9:  begin op = OP_XOR;  tag = "R1"; end
      10: begin op = OP_OR;   tag = "R1"; end
      39: begin op = OP_MUL;  tag = "R3"; end
      default: ;
    endcase
    if (op != OP_ILLEGAL) begin rd = d; rr = r; used = 3; return; end
    case (w >> 12)
      7: op = OP_ANDK;
      6: op = OP_ORK;
      5: op = OP_SUBK;
      4: op = OP_SUBCK;
      default: ;
    endcase
    if (op != OP_ILLEGAL) begin
      rd = 16 + ((w >> 4) & 15); imm = ((w >> 8) & 15) * 16 + lo; used = 5; tag = "R4"; return;
    end
    if ((w >> 9) == 74) begin
      case (lo)
        0: op = OP_NOT;   2: op = OP_NSWAP; 3: op = OP_INC;
        5: op = OP_SHRA;  6: op = OP_SHRL; 10: op = OP_DEC;
        default: ;
      endcase
      if (op != OP_ILLEGAL) begin rd = d; used = 1; tag = "R5"; end
      return;
    end
    if ((w >> 11) == 22 || (w >> 11) == 23) begin
      io = ((w >> 9) & 3) * 16 + lo; tag = "R6";
      if ((w >> 11) == 22) begin op = OP_PIN;  rd = d; used = 9;  end
      else                 begin op = OP_POUT; rr = d; used = 10; end
      return;
    end
    if (lo == 15 && (w >> 9) == 73) begin op = OP_PUSH; rr = d; used = 2; tag = "R7"; return; end
    if (lo == 15 && (w >> 9) == 72) begin op = OP_POP;  rd = d; used = 1; tag = "R7"; return; end
    if ((w >> 8) == 'h98 || (w >> 8) == 'h9A) begin
      op = ((w >> 8) == 'h98) ? OP_BCLR : OP_BSET;
      io = (w >> 3) & 31; bt = w & 7; used = 24; tag = "R8"; return;
    end
    if ((w >> 8) == 'h96 || (w >> 8) == 'h97) begin
      op = ((w >> 8) == 'h96) ? OP_WADDK : OP_WSUBK;
      pr = (w >> 4) & 3; rd = 24 + 2 * pr; imm = ((w >> 6) & 3) * 16 + lo;
      used = 37; tag = "R9";
    end
  endtask

  task automatic check_word(int w);
    op_e op; int rd, rr, imm, io, bt, pr, used; string tag;
    model(w, op, rd, rr, imm, io, bt, pr, used, tag);
    chk(tag, "op", w, op_o, op);
    chk(tag, "illegal", w, illegal_o, op == OP_ILLEGAL);
    chk(used[0] ? tag : "R11", "rd",   w, rd_o, rd);
    chk(used[1] ? tag : "R11", "rr",   w, rr_o, rr);
    chk(used[2] ? tag : "R11", "imm",  w, imm_o, imm);
    chk(used[3] ? tag : "R11", "io",   w, io_addr_o, io);
    chk(used[4] ? tag : "R11", "bit",  w, bit_o, bt);
    chk(used[5] ? tag : "R11", "pair", w, pair_o, pr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int directed [16] = '{'h0000, 'h0C00, 'h0FFF, 'h0C01, 'h9FFF, 'h7FFF, 'h40A5, 'hB7FF,
                          'hBE10, 'h9A07, 'h98F8, 'h96FF, 'h97C0, 'h920F, 'h910F, 'h940B};
    // reset state: word zero is illegal (R10)
    repeat (3) @(negedge clk);
    check_word(0);
    rst_ni = 1'b1;
    foreach (directed[i]) begin
      @(posedge clk); word = 16'(directed[i]);
      @(negedge clk); check_word(directed[i]);
    end
    // R12: change mid-cycle, outputs follow before the next edge
    @(negedge clk); word = 16'h9403;
    #2 chk("R12", "op", 'h9403, op_o, OP_INC);
    chk("R12", "rd", 'h9403, rd_o, 0);
    for (int w = 0; w < 65536; w++) begin
      @(posedge clk); word = 16'(w);
      @(negedge clk); check_word(w);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule